// File: doc/BRIEF.md
# Character LCD Host Bus Driver

This block sits between an on-chip requester and the parallel bus of a character LCD module. The requester hands over one transfer at a time on a valid/ready handshake: a register-select bit (command or display data), a direction bit and, for writes, a byte. The driver turns each request into properly timed strobes on the module's select, direction, enable and eight data lines, with a separate output enable so that the data lines can be shared for reads.

Every request starts with a status read: the driver reads the module's busy flag and address counter and repeats that read until the flag is clear. Only then does it perform the requested transfer. The bus can run with all eight data lines or with only the upper four, in which case every byte, including the status byte, moves as two strobes with the upper half first. When the transfer finishes, the driver returns a one-cycle response carrying the byte read (for reads), the address counter from the last status read, and a timeout flag. The timeout fires when the module stays busy for a programmable number of status reads; the requested transfer is then abandoned.

Top module: `lcd_bus_driver`

## Requirements
- R1: After a synchronous active-low reset, `lcd_e` and `lcd_db_oe` are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `lcd_rs` = 0 selects the instruction side and 1 the data side; `lcd_rw` = 1 is a read from the module. Status reads use `lcd_rs`=0, `lcd_rw`=1; the requested transfer uses the request's `req_rs` and `req_rw`.
- R3: With each figure converted to clock cycles as ceil(ns*1000/CLK_PERIOD_PS): `lcd_e` stays high at least 230 ns, successive rising edges of `lcd_e` are at least 500 ns apart, `lcd_rs`/`lcd_rw`/`lcd_db_out`/`lcd_db_oe` are stable at least 140 ns before `lcd_e` rises and do not change until at least 10 ns after it falls.
- R4: `lcd_db_oe` is 1 only during strobes of a write transfer and never while `lcd_rw` is 1; written data is valid while `lcd_db_oe` is 1.
- R5: With `cfg_nibble` = 0 the requested transfer takes one strobe carrying the full byte on `lcd_db_out[7:0]`.
- R6: With `cfg_nibble` = 1 the requested transfer takes two strobes, bits 7..4 first and then bits 3..0, each on `lcd_db_out[7:4]` (and `lcd_db_in[7:4]` for reads).
- R7: Before every transfer the driver performs status reads and repeats them while the busy flag (`lcd_db_in[7]` of a status read) is 1; no transfer strobe follows a status read that returned busy.
- R8: A status read returns the busy flag on bit 7 and the address counter on bits 6..0. With `cfg_nibble` = 1 it uses two strobes: the flag and counter bits 6..4 come from the first, counter bits 3..0 from the second. `rsp_addr` carries the counter from the last status read.
- R9: For a read, `rsp_rdata` returns the byte read from the module, sampled in the last cycle of `lcd_e` high (assembled upper half first in 4-bit mode); for a write or a timed-out request it is 0.
- R10: `rsp_valid` is high for exactly one cycle per accepted request; `req_ready` is low from acceptance until that response.
- R11: When `cfg_poll_limit` is nonzero and that many consecutive status reads return busy, no transfer strobe is issued and the response has `rsp_timeout` = 1; a limit of 0 never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_nibble | input | 1 | 1 = four-line bus mode, 0 = eight-line mode |
| cfg_poll_limit | input | LIMIT_W | Busy status reads allowed before timeout, 0 = unlimited |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Driver idle and accepting a request |
| req_rs | input | 1 | Register select of the request (0 instruction, 1 data) |
| req_rw | input | 1 | Direction of the request (1 read) |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read from the module |
| rsp_addr | output | 7 | Address counter from the last status read |
| rsp_timeout | output | 1 | Request abandoned because the module stayed busy |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus direction |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data lines driven toward the module |
| lcd_db_oe | output | 1 | Output enable for the data lines |
| lcd_db_in | input | 8 | Data lines as seen from the module |

## Verification
The response pulse is due one clock after the edge that ends the hold (or idle gap) of the last strobe, so the bench waits for `rsp_valid` on falling clock edges rather than counting a fixed latency, and then compares the strobe counts, captured write byte, read byte, address and timeout flag with values derived from the programmed busy count and limit. Bus timing is measured cycle by cycle on falling edges: setup is counted from the last change of the control and data lines to the rising enable, high time and rise-to-rise spacing from enable edges, and hold from the falling enable to the next line change. The model of the module answers status and data reads combinationally while the enable is high, so the sample taken in the last high cycle always sees settled data.

// File: rtl/lcd_bus_pkg.sv
// Shared types and helpers for the character LCD bus driver.
// Assumes: all timing figures are given in ns and the clock period in ps.
package lcd_bus_pkg;

    // Sequencer states of the request engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_A,
        ST_POLL_B,
        ST_XFER_A,
        ST_XFER_B
    } drv_state_t;

    // Phases of a single enable strobe.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_GAP
    } strobe_phase_t;

    // Converts a minimum time into clock cycles, rounded up, at least one.
    function automatic int cycles_for(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/lcd_strobe_gen.sv
// Enable strobe generator.
// One start pulse produces one strobe: SETUP cycles with enable low, HIGH
// cycles with enable high, HOLD cycles with enable low, then an idle gap that
// pads the strobe to the minimum rise-to-rise spacing. The caller must keep the
// select, direction and data lines constant while `active` is high and may
// change them on the cycle `done` is high.
// Assumes: every length parameter is at least 1.
module lcd_strobe_gen
    import lcd_bus_pkg::*;
#(
    parameter int SETUP_CYC = 18,
    parameter int HIGH_CYC  = 29,
    parameter int HOLD_CYC  = 2,
    parameter int CYCLE_CYC = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe_e,
    output logic active,
    output logic sample,
    output logic done
);

    localparam int SPAN    = SETUP_CYC + HIGH_CYC + HOLD_CYC;
    localparam int GAP_CYC = (CYCLE_CYC > SPAN) ? (CYCLE_CYC - SPAN) : 0;
    localparam int LEN_A   = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int LEN_B   = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAX_LEN = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HIGH  = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'((GAP_CYC > 0) ? GAP_CYC - 1 : 0);

    strobe_phase_t    phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             e_q;

    // Next phase and down-counter of the current strobe.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        done    = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_SETUP;
                    cnt_d   = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    phase_d = PH_HIGH;
                    cnt_d   = LD_HIGH;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    phase_d = PH_HOLD;
                    cnt_d   = LD_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    if (GAP_CYC > 0) begin
                        phase_d = PH_GAP;
                        cnt_d   = LD_GAP;
                    end else begin
                        phase_d = PH_IDLE;
                        done    = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_GAP: begin
                if (cnt_q == '0) begin
                    phase_d = PH_IDLE;
                    done    = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase, counter and a registered enable so the strobe is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            e_q     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            e_q     <= (phase_d == PH_HIGH);
        end
    end

    assign strobe_e = e_q;
    assign active   = (phase_q != PH_IDLE);
    assign sample   = (phase_q == PH_HIGH) && (cnt_q == '0);

    // Independent measurement of high time and rise spacing for the checks.
    logic [15:0] hi_len_q;
    logic [15:0] rise_gap_q;
    logic        rise_now;

    assign rise_now = (phase_q == PH_SETUP) && (cnt_q == '0);

    // Counts cycles of enable high and cycles since the last rising enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len_q   <= '0;
            rise_gap_q <= '1;
        end else begin
            hi_len_q <= e_q ? hi_len_q + 16'd1 : 16'd0;
            if (rise_now)
                rise_gap_q <= '0;
            else if (rise_gap_q != '1)
                rise_gap_q <= rise_gap_q + 16'd1;
        end
    end

    // R3
    e_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_q) |-> (hi_len_q == 16'(HIGH_CYC)));

    // R3
    e_rise_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_now |-> (rise_gap_q >= 16'(CYCLE_CYC - 1)));

endmodule

// File: rtl/lcd_poll_watch.sv
// Busy-read watchdog.
// Counts status reads that returned busy within one request and reports when
// the next busy read would reach the programmed limit. A limit of zero
// disables the timeout.
// Assumes: `clear` is held while the engine is idle, `hit` marks one busy read.
module lcd_poll_watch #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               hit,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expire
);

    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W:0]   next_cnt;

    // Busy-read counter, cleared between requests.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (hit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign next_cnt = (LIMIT_W+1)'(cnt_q) + 1'b1;
    assign expire   = (limit != '0) && (next_cnt >= (LIMIT_W+1)'(limit));

    // R11
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ((limit == '0) || (cnt_q < limit)));

    // R11
    hit_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !expire);

endmodule

// File: rtl/lcd_bus_driver.sv
// Character LCD host bus driver (top).
// Accepts one request at a time, performs status reads until the module
// reports not busy, then performs the requested read or write in eight-line
// or four-line mode, and returns a single-cycle response.
// Assumes: lcd_db_in is driven by the module while lcd_e is high on reads;
// cfg_nibble and cfg_poll_limit stay constant during a request.
module lcd_bus_driver
    import lcd_bus_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int T_SETUP_NS    = 140,
    parameter int T_HIGH_NS     = 230,
    parameter int T_HOLD_NS     = 10,
    parameter int T_CYCLE_NS    = 500,
    parameter int LIMIT_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_nibble,
    input  logic [LIMIT_W-1:0] cfg_poll_limit,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_rs,
    input  logic               req_rw,
    input  logic [7:0]         req_wdata,
    output logic               rsp_valid,
    output logic [7:0]         rsp_rdata,
    output logic [6:0]         rsp_addr,
    output logic               rsp_timeout,
    output logic               lcd_rs,
    output logic               lcd_rw,
    output logic               lcd_e,
    output logic [7:0]         lcd_db_out,
    output logic               lcd_db_oe,
    input  logic [7:0]         lcd_db_in
);

    localparam int SETUP_CYC = cycles_for(T_SETUP_NS, CLK_PERIOD_PS);
    localparam int HIGH_CYC  = cycles_for(T_HIGH_NS, CLK_PERIOD_PS);
    localparam int HOLD_CYC  = cycles_for(T_HOLD_NS, CLK_PERIOD_PS);
    localparam int CYCLE_CYC = cycles_for(T_CYCLE_NS, CLK_PERIOD_PS);

    drv_state_t  state_q;
    logic        start_q;
    logic        strobe_active, strobe_sample, strobe_done;

    // Latched request.
    logic        rs_l, rw_l, nib_l;
    logic [7:0]  wd_l;

    // Bus line registers.
    logic        bus_rs_q, bus_rw_q, bus_oe_q;
    logic [7:0]  bus_db_q;

    // Captured status and data.
    logic        flag_q;
    logic [6:0]  ac_q;
    logic [7:0]  rd_q;
    logic        rsp_valid_q, timeout_q;

    logic        poll_end, poll_hit, poll_expire, watch_clear;

    lcd_strobe_gen #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .CYCLE_CYC (CYCLE_CYC)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_q),
        .strobe_e (lcd_e),
        .active   (strobe_active),
        .sample   (strobe_sample),
        .done     (strobe_done)
    );

    assign poll_end    = strobe_done &&
                         ((state_q == ST_POLL_B) || ((state_q == ST_POLL_A) && !nib_l));
    assign poll_hit    = poll_end && flag_q && !poll_expire;
    assign watch_clear = (state_q == ST_IDLE);

    lcd_poll_watch #(
        .LIMIT_W (LIMIT_W)
    ) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (watch_clear),
        .hit    (poll_hit),
        .limit  (cfg_poll_limit),
        .expire (poll_expire)
    );

    // Captures status and read data in the last cycle of enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ac_q   <= '0;
        end else if (strobe_sample) begin
            if (state_q == ST_POLL_A) begin
                flag_q <= lcd_db_in[7];
                if (nib_l)
                    ac_q[6:4] <= lcd_db_in[6:4];
                else
                    ac_q <= lcd_db_in[6:0];
            end else if (state_q == ST_POLL_B) begin
                ac_q[3:0] <= lcd_db_in[7:4];
            end
        end
    end

    // Request engine: status reads, transfer strobes and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            start_q     <= 1'b0;
            rs_l        <= 1'b0;
            rw_l        <= 1'b0;
            nib_l       <= 1'b0;
            wd_l        <= '0;
            bus_rs_q    <= 1'b0;
            bus_rw_q    <= 1'b1;
            bus_oe_q    <= 1'b0;
            bus_db_q    <= '0;
            rd_q        <= '0;
            rsp_valid_q <= 1'b0;
            timeout_q   <= 1'b0;
        end else begin
            start_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rs_l      <= req_rs;
                        rw_l      <= req_rw;
                        nib_l     <= cfg_nibble;
                        wd_l      <= req_wdata;
                        rd_q      <= '0;
                        timeout_q <= 1'b0;
                        bus_rs_q  <= 1'b0;
                        bus_rw_q  <= 1'b1;
                        bus_oe_q  <= 1'b0;
                        start_q   <= 1'b1;
                        state_q   <= ST_POLL_A;
                    end
                end
                ST_POLL_A, ST_POLL_B: begin
                    if (strobe_done) begin
                        if ((state_q == ST_POLL_A) && nib_l) begin
                            start_q <= 1'b1;
                            state_q <= ST_POLL_B;
                        end else if (flag_q) begin
                            if (poll_expire) begin
                                timeout_q   <= 1'b1;
                                rsp_valid_q <= 1'b1;
                                state_q     <= ST_IDLE;
                            end else begin
                                start_q <= 1'b1;
                                state_q <= ST_POLL_A;
                            end
                        end else begin
                            bus_rs_q <= rs_l;
                            bus_rw_q <= rw_l;
                            bus_oe_q <= !rw_l;
                            bus_db_q <= nib_l ? {wd_l[7:4], 4'h0} : wd_l;
                            start_q  <= 1'b1;
                            state_q  <= ST_XFER_A;
                        end
                    end
                end
                ST_XFER_A: begin
                    if (strobe_sample && rw_l) begin
                        if (nib_l)
                            rd_q[7:4] <= lcd_db_in[7:4];
                        else
                            rd_q <= lcd_db_in;
                    end
                    if (strobe_done) begin
                        if (nib_l) begin
                            bus_db_q <= {wd_l[3:0], 4'h0};
                            start_q  <= 1'b1;
                            state_q  <= ST_XFER_B;
                        end else begin
                            bus_oe_q    <= 1'b0;
                            rsp_valid_q <= 1'b1;
                            state_q     <= ST_IDLE;
                        end
                    end
                end
                ST_XFER_B: begin
                    if (strobe_sample && rw_l)
                        rd_q[3:0] <= lcd_db_in[7:4];
                    if (strobe_done) begin
                        bus_oe_q    <= 1'b0;
                        rsp_valid_q <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = rsp_valid_q;
    assign rsp_rdata   = rd_q;
    assign rsp_addr    = ac_q;
    assign rsp_timeout = timeout_q;
    assign lcd_rs      = bus_rs_q;
    assign lcd_rw      = bus_rw_q;
    assign lcd_db_out  = bus_db_q;
    assign lcd_db_oe   = bus_oe_q;

    // R3
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_active |-> ($stable(lcd_rs) && $stable(lcd_rw) &&
                           $stable(lcd_db_oe) && $stable(lcd_db_out)));

    // R4
    oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rw);

    // R7
    xfer_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER_A) && ($past(state_q) != ST_XFER_A)) |-> !flag_q);

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !strobe_active);

endmodule

// File: tb/lcd_bus_driver_bench.sv
`timescale 1ns/1ps
// Bench for lcd_bus_driver: a behavioural LCD module model, a cycle-level
// bus timing monitor, directed corner cases and seeded random requests.
module lcd_bus_driver_bench;

    localparam int PERIOD_PS = 8000;
    localparam int SETUP_CYC = (140 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int HIGH_CYC  = (230 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int HOLD_CYC  = (10 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int CYCLE_CYC = (500 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int WD_LIMIT  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nibble = 1'b0;
    logic [15:0] cfg_poll_limit = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_rs = 1'b0;
    logic        req_rw = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [6:0]  rsp_addr;
    logic        rsp_timeout;
    logic        lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0]  lcd_db_out;
    logic [7:0]  lcd_db_in;

    always #4 clk = ~clk;

    lcd_bus_driver u_lcd_bus_driver (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_nibble     (cfg_nibble),
        .cfg_poll_limit (cfg_poll_limit),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_rs         (req_rs),
        .req_rw         (req_rw),
        .req_wdata      (req_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_addr       (rsp_addr),
        .rsp_timeout    (rsp_timeout),
        .lcd_rs         (lcd_rs),
        .lcd_rw         (lcd_rw),
        .lcd_e          (lcd_e),
        .lcd_db_out     (lcd_db_out),
        .lcd_db_oe      (lcd_db_oe),
        .lcd_db_in      (lcd_db_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit wd_hit   = 1'b0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Module model state.
    bit         m_nib = 1'b0;
    bit         m_half = 1'b0;
    int         m_busy_left = 0;
    logic [6:0] m_ac = '0;
    logic [7:0] m_rbyte = '0;
    int         m_polls = 0;
    int         m_xfers = 0;
    logic [7:0] m_wr = '0;
    bit         m_rs_seen = 1'b0;
    bit         m_oe_bad = 1'b0;

    // Module answers reads while enable is high.
    logic [7:0] m_byte;
    always_comb begin
        m_byte    = (!lcd_rs) ? {(m_busy_left > 0), m_ac} : m_rbyte;
        lcd_db_in = 8'h00;
        if (lcd_e && lcd_rw)
            lcd_db_in = m_nib ? (m_half ? {m_byte[3:0], 4'h0} : {m_byte[7:4], 4'h0}) : m_byte;
    end

    // Bus timing monitor and model update on falling clock edges.
    logic       p_rs = 1'b0, p_rw = 1'b1, p_oe = 1'b0, p_e = 1'b0;
    logic [7:0] p_db = '0;
    int         stable_cnt = 0, since_fall = 100000, since_rise = 100000, hi_cnt = 0;
    bit         chg;

    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !wd_hit) begin
            wd_hit = 1'b1;
            chk(1'b0, "WATCHDOG", cyc, WD_LIMIT);
        end
        chg = (lcd_rs !== p_rs) || (lcd_rw !== p_rw) || (lcd_db_oe !== p_oe) || (lcd_db_out !== p_db);
        since_fall++;
        since_rise++;
        stable_cnt = chg ? 0 : stable_cnt + 1;
        if (rst_n && chg) // R3 hold after enable falls
            chk(!lcd_e && since_fall >= HOLD_CYC, "R3 hold", since_fall, HOLD_CYC);
        if (rst_n && lcd_e && !p_e) begin
            chk(stable_cnt >= SETUP_CYC, "R3 setup", stable_cnt, SETUP_CYC);
            chk(since_rise >= CYCLE_CYC, "R3 cycle", since_rise, CYCLE_CYC);
            since_rise = 0;
            hi_cnt = 0;
        end
        if (lcd_e) hi_cnt++;
        if (rst_n && lcd_e && lcd_rw && lcd_db_oe)
            chk(1'b0, "R4 oe during read", 1, 0);
        if (rst_n && !lcd_e && p_e) begin
            chk(hi_cnt >= HIGH_CYC, "R3 high", hi_cnt, HIGH_CYC);
            since_fall = 0;
            if (lcd_rw && !lcd_rs) begin
                m_polls++;
                if ((!m_nib || m_half) && m_busy_left > 0) m_busy_left--;
            end else begin
                m_xfers++;
                m_rs_seen = lcd_rs;
                if (!lcd_rw) begin
                    if (!lcd_db_oe) m_oe_bad = 1'b1;
                    if (m_nib) begin
                        if (m_half) m_wr[3:0] = lcd_db_out[7:4];
                        else        m_wr[7:4] = lcd_db_out[7:4];
                    end else begin
                        m_wr = lcd_db_out;
                    end
                end
            end
            if (m_nib) m_half = !m_half;
        end
        p_rs = lcd_rs; p_rw = lcd_rw; p_oe = lcd_db_oe; p_db = lcd_db_out; p_e = lcd_e;
    end

    function automatic bit exp_timeout(input int busy, input int limit);
        return (limit != 0) && (busy >= limit);
    endfunction

    function automatic int exp_poll_pulses(input int busy, input int limit, input bit nib);
        int n;
        n = exp_timeout(busy, limit) ? limit : busy + 1;
        return nib ? 2 * n : n;
    endfunction

    task automatic run_req(input bit rs, input bit rw, input logic [7:0] wd, input bit nib,
                           input int busy, input logic [6:0] ac, input logic [7:0] rb,
                           input int limit);
        bit to;
        @(negedge clk);
        cfg_nibble     = nib;
        cfg_poll_limit = 16'(limit);
        m_nib = nib; m_half = 1'b0; m_busy_left = busy; m_ac = ac; m_rbyte = rb;
        m_polls = 0; m_xfers = 0; m_wr = '0; m_oe_bad = 1'b0; m_rs_seen = 1'b0;
        req_rs = rs; req_rw = rw; req_wdata = wd; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R10 ready when idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R10 not ready while busy", int'(req_ready), 0);
        while (!rsp_valid && !wd_hit) @(negedge clk);
        to = exp_timeout(busy, limit);
        chk(rsp_timeout === to, "R11 timeout flag", int'(rsp_timeout), int'(to));
        chk(m_polls == exp_poll_pulses(busy, limit, nib), "R7 R8 status strobes",
            m_polls, exp_poll_pulses(busy, limit, nib));
        chk(m_xfers == (to ? 0 : (nib ? 2 : 1)), "R5 R6 transfer strobes",
            m_xfers, to ? 0 : (nib ? 2 : 1));
        chk(rsp_addr === ac, "R8 address counter", int'(rsp_addr), int'(ac));
        if (!to && !rw) begin
            chk(m_wr === wd, "R6 written byte", int'(m_wr), int'(wd));
            chk(!m_oe_bad, "R4 oe on write", int'(m_oe_bad), 0);
            chk(m_rs_seen == rs, "R2 select on transfer", int'(m_rs_seen), int'(rs));
        end
        chk(rsp_rdata === ((!to && rw) ? rb : 8'h00), "R9 read data",
            int'(rsp_rdata), int'((!to && rw) ? rb : 8'h00));
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R10 single response", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(lcd_e === 1'b0, "R1 enable low", int'(lcd_e), 0);
        chk(lcd_db_oe === 1'b0, "R1 oe low", int'(lcd_db_oe), 0);
        chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1 no response", int'(rsp_valid), 0);

        // Directed corner cases.
        run_req(1'b0, 1'b0, 8'h38, 1'b0, 0, 7'h00, 8'h00, 4); // R5 R2 command write
        run_req(1'b1, 1'b0, 8'hA5, 1'b0, 2, 7'h15, 8'h00, 4); // R7 busy twice
        run_req(1'b1, 1'b1, 8'h00, 1'b0, 1, 7'h2A, 8'h3C, 4); // R9 eight-line read
        run_req(1'b1, 1'b0, 8'h6B, 1'b1, 0, 7'h51, 8'h00, 3); // R6 four-line write
        run_req(1'b1, 1'b1, 8'h00, 1'b1, 3, 7'h6E, 8'hD2, 5); // R8 R9 four-line read
        run_req(1'b0, 1'b0, 8'h01, 1'b0, 5, 7'h7F, 8'h00, 2); // R11 timeout
        run_req(1'b1, 1'b1, 8'h00, 1'b1, 3, 7'h33, 8'h99, 3); // R11 busy equals limit
        run_req(1'b0, 1'b0, 8'h0C, 1'b0, 6, 7'h04, 8'h00, 0); // R11 limit zero
        run_req(1'b1, 1'b0, 8'hF0, 1'b1, 1, 7'h40, 8'h00, 2); // R11 one below limit

        // Seeded random requests.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 14 && !wd_hit; i++) begin
            bit rw;
            bit rs;
            int lim;
            rw  = 1'($urandom % 2);
            rs  = rw ? 1'b1 : 1'($urandom % 2);
            lim = (($urandom % 3) == 0) ? 0 : 1 + int'($urandom % 4);
            run_req(rs, rw, 8'($urandom), 1'($urandom % 2), int'($urandom % 4),
                    7'($urandom), 8'($urandom), lim);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule